// File: doc/BRIEF.md
# Token-Network Node Status and Interrupt Register

This block holds the status byte of a token-passing network node controller and raises the interrupt line for it. Six event flags live in an 8-bit word. Each flag has its own set events and its own clear commands. Three kinds of input drive the flags:

- single-cycle event strobes from the receive path, the transmit path and the reset logic;
- single-cycle command strobes from the host command decoder;
- an interrupt mask register that the host writes.

A line-idle timer also watches the asynchronous receive line. If the line stops toggling for a parameterised number of clock cycles, the timer sets the reconfiguration flag. By default this window is 41 µs, derived from the clock frequency.

The status byte is a plain output that the host read path can sample. While the receiver is inhibited, an incoming packet addressed to this node raises a NAK request in the same cycle. The interrupt output is a level: it stays high while any interrupt-capable flag is set together with its mask bit.

All flag updates take effect at the clock edge that samples the strobe. The NAK request and the interrupt are combinational from the registered state and the current inputs.

Top module: `tnc_status_irq`

## Requirements
- R1: After reset the status byte reads 0x91 (receiver-inhibit bit 7, power-on bit 4 and transmitter-available bit 0 set, all others clear), the mask register is zero and the interrupt is low.
- R2: The receiver-inhibit flag (status bit 7) is set by `rx_stored_i` and cleared only by `cmd_en_rx_i`.
- R3: `nak_req_o` is high in exactly the cycles where `rx_for_me_i` is high while status bit 7 is set.
- R4: The power-on flag (bit 4) is set by `sw_reset_i`, or by `nodeid_wr_i` when `nodeid_data_i` is 0x00. It is cleared only by `cmd_clr_flags_i`. A write of a non-zero node ID leaves it unchanged.
- R5: The reconfiguration flag (bit 2) is set when the synchronised receive line has shown no transition for IDLE cycles (CLK_HZ × IDLE_NS / 1e9). Every transition restarts that count. The flag is cleared by `cmd_clr_flags_i`.
- R6: The acknowledged flag (bit 1) is set by `tx_acked_i` only when `tx_bcast_i` is low. It is cleared by `cmd_en_tx_i`.
- R7: The transmitter-available flag (bit 0) is set by `tx_done_i` or `cmd_dis_tx_i`. It is cleared by the first `token_rx_i` that follows a `cmd_en_tx_i`. A token with no pending enable-transmit leaves it unchanged, and `cmd_dis_tx_i` cancels a pending enable-transmit.
- R8: Status bits 6, 5 and 3 always read 0.
- R9: `irq_o` equals (bit7 & mask[7]) | (bit2 & mask[2]) | (bit0 & mask[0]). The mask is loaded from `mask_data_i` on `mask_wr_i`, and the other mask bits have no effect.
- R10: When a set event and a clear event reach the same flag in one cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| rx_line_i | input | 1 | Asynchronous receive line watched by the idle timer |
| rx_stored_i | input | 1 | Received packet written to the enabled page |
| rx_for_me_i | input | 1 | Incoming packet addressed to this node |
| tx_done_i | input | 1 | Last byte of the scheduled packet sent |
| tx_acked_i | input | 1 | Sent packet acknowledged |
| tx_bcast_i | input | 1 | Qualifies tx_acked_i: packet was broadcast |
| token_rx_i | input | 1 | Node received the token |
| cmd_en_rx_i | input | 1 | Enable-receive command |
| cmd_en_tx_i | input | 1 | Enable-transmit command |
| cmd_dis_tx_i | input | 1 | Disable-transmitter command |
| cmd_clr_flags_i | input | 1 | Clear-flags command |
| sw_reset_i | input | 1 | Software reset strobe |
| nodeid_wr_i | input | 1 | Host write of the node ID register |
| nodeid_data_i | input | 8 | Node ID write data |
| mask_wr_i | input | 1 | Host write of the interrupt mask |
| mask_data_i | input | 8 | Interrupt mask write data |
| status_o | output | 8 | Status byte |
| nak_req_o | output | 1 | Request to answer the incoming packet with NAK |
| irq_o | output | 1 | Level interrupt |

## Verification
Set events and clear commands for the same flag can fall in one cycle. The pairs are a stored packet with an enable-receive command, a token with a last-byte strobe, an acknowledgement with an enable-transmit command, and an idle timeout or software reset with clear-flags.

The bench drives such pairs in directed steps. It also lets them coincide by chance in a long random phase with sparse strobes and a rarely toggling receive line. In every case a behavioural reference model, updated on each edge, predicts that the flag ends set, and the status byte, NAK request and interrupt are compared against it every cycle.

// File: rtl/tnc_status_pkg.sv
package tnc_status_pkg;
   localparam int unsigned STATUS_W = 8;
   localparam int unsigned BIT_RI    = 7;
   localparam int unsigned BIT_POR   = 4;
   localparam int unsigned BIT_TEST  = 3;
   localparam int unsigned BIT_RECON = 2;
   localparam int unsigned BIT_TMA   = 1;
   localparam int unsigned BIT_TA    = 0;
   localparam logic [STATUS_W-1:0] IRQ_SOURCES =
      STATUS_W'((1 << BIT_RI) | (1 << BIT_RECON) | (1 << BIT_TA));
   localparam logic [STATUS_W-1:0] RESET_STATUS =
      STATUS_W'((1 << BIT_RI) | (1 << BIT_POR) | (1 << BIT_TA));
endpackage

// File: rtl/tnc_flag_cell.sv
module tnc_flag_cell #(
   parameter bit RST_VAL  = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)    q_o <= RST_VAL;
            else if (set_i) q_o <= 1'b1;
            else if (clr_i) q_o <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)    q_o <= RST_VAL;
            else if (clr_i) q_o <= 1'b0;
            else if (set_i) q_o <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/tnc_idle_timer.sv
module tnc_idle_timer #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDLE_CYC    = 820
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic expire_o
);
   localparam int unsigned CNT_W = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYC - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tnc_idle_timer: SYNC_STAGES must be at least 2");
      end
      if (IDLE_CYC < 2) begin : g_bad_idle
         $error("tnc_idle_timer: IDLE_CYC must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES:0] shift_q;
   logic [CNT_W-1:0]     cnt_q;
   logic                 toggled;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shift_q <= '0;
      else         shift_q <= {shift_q[SYNC_STAGES-1:0], line_i};
   end

   assign toggled  = shift_q[SYNC_STAGES-1] ^ shift_q[SYNC_STAGES];
   assign expire_o = !toggled && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (toggled || expire_o) cnt_q <= '0;
      else                          cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/tnc_irq_gen.sv
module tnc_irq_gen
   import tnc_status_pkg::*;
(
   input  logic [STATUS_W-1:0] status_i,
   input  logic [STATUS_W-1:0] mask_i,
   output logic                irq_o
);
   logic [STATUS_W-1:0] hit;
   generate
      for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
         if (IRQ_SOURCES[i]) begin : g_src
            assign hit[i] = status_i[i] & mask_i[i];
         end else begin : g_none
            assign hit[i] = 1'b0;
         end
      end
   endgenerate
   assign irq_o = |hit;
endmodule

// File: rtl/tnc_status_irq.sv
module tnc_status_irq
   import tnc_status_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 20_000_000,
   parameter int unsigned IDLE_NS     = 41_000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SET_WINS    = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                rx_line_i,
   input  logic                rx_stored_i,
   input  logic                rx_for_me_i,
   input  logic                tx_done_i,
   input  logic                tx_acked_i,
   input  logic                tx_bcast_i,
   input  logic                token_rx_i,
   input  logic                cmd_en_rx_i,
   input  logic                cmd_en_tx_i,
   input  logic                cmd_dis_tx_i,
   input  logic                cmd_clr_flags_i,
   input  logic                sw_reset_i,
   input  logic                nodeid_wr_i,
   input  logic [7:0]          nodeid_data_i,
   input  logic                mask_wr_i,
   input  logic [7:0]          mask_data_i,
   output logic [STATUS_W-1:0] status_o,
   output logic                nak_req_o,
   output logic                irq_o
);
   localparam longint unsigned IDLE_L =
      (longint'(CLK_HZ) * longint'(IDLE_NS)) / 64'd1_000_000_000;
   localparam int unsigned IDLE_CYC = int'(IDLE_L);

   generate
      if (STATUS_W != 8) begin : g_bad_width
         $error("tnc_status_irq: status word must be 8 bits");
      end
   endgenerate

   logic ri_q, por_q, recon_q, tma_q, ta_q;
   logic por_set, ta_clr, idle_expire, tx_arm_q;
   logic [STATUS_W-1:0] mask_q;

   assign por_set = sw_reset_i | (nodeid_wr_i && (nodeid_data_i == 8'h00));
   assign ta_clr  = token_rx_i & tx_arm_q;

   tnc_idle_timer #(.SYNC_STAGES(SYNC_STAGES), .IDLE_CYC(IDLE_CYC)) u_idle (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(rx_line_i), .expire_o(idle_expire));

   tnc_flag_cell #(.RST_VAL(1'b1), .SET_WINS(SET_WINS)) u_ri (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(rx_stored_i),
      .clr_i(cmd_en_rx_i), .q_o(ri_q));
   tnc_flag_cell #(.RST_VAL(1'b1), .SET_WINS(SET_WINS)) u_por (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(por_set),
      .clr_i(cmd_clr_flags_i), .q_o(por_q));
   tnc_flag_cell #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_recon (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(idle_expire),
      .clr_i(cmd_clr_flags_i), .q_o(recon_q));
   tnc_flag_cell #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_tma (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(tx_acked_i & ~tx_bcast_i),
      .clr_i(cmd_en_tx_i), .q_o(tma_q));
   tnc_flag_cell #(.RST_VAL(1'b1), .SET_WINS(SET_WINS)) u_ta (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(tx_done_i | cmd_dis_tx_i),
      .clr_i(ta_clr), .q_o(ta_q));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    tx_arm_q <= 1'b0;
      else if (cmd_en_tx_i)           tx_arm_q <= 1'b1;
      else if (ta_clr | cmd_dis_tx_i) tx_arm_q <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_q <= '0;
      else if (mask_wr_i) mask_q <= mask_data_i;
   end

   always_comb begin
      status_o            = '0;
      status_o[BIT_RI]    = ri_q;
      status_o[BIT_POR]   = por_q;
      status_o[BIT_TEST]  = 1'b0;
      status_o[BIT_RECON] = recon_q;
      status_o[BIT_TMA]   = tma_q;
      status_o[BIT_TA]    = ta_q;
   end

   assign nak_req_o = rx_for_me_i & ri_q;

   tnc_irq_gen u_irq (.status_i(status_o), .mask_i(mask_q), .irq_o(irq_o));
endmodule

// File: rtl/tnc_status_checker.sv
module tnc_status_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [7:0] status_o,
   input logic       nak_req_o,
   input logic       irq_o,
   input logic [7:0] mask_q,
   input logic       rx_stored_i,
   input logic       cmd_en_rx_i,
   input logic       tx_acked_i,
   input logic       tx_bcast_i,
   input logic       cmd_clr_flags_i,
   input logic       por_set,
   input logic       idle_expire
);
   p_ri_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_stored_i |=> status_o[7]);
   p_ri_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[7] && !cmd_en_rx_i) |=> status_o[7]);
   p_nak_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !status_o[7] |-> !nak_req_o);
   p_por_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_clr_flags_i && !por_set) |=> !status_o[4]);
   p_recon_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[2]) |-> $past(idle_expire));
   p_tma_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[1]) |-> $past(tx_acked_i && !tx_bcast_i));
   p_zero_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[6:5] == 2'b00) && !status_o[3]);
   p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ((status_o & mask_q & 8'h85) != 8'h00));
   p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_stored_i && cmd_en_rx_i) |=> status_o[7]);
endmodule

bind tnc_status_irq tnc_status_checker u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .status_o(status_o), .nak_req_o(nak_req_o),
   .irq_o(irq_o), .mask_q(mask_q), .rx_stored_i(rx_stored_i),
   .cmd_en_rx_i(cmd_en_rx_i), .tx_acked_i(tx_acked_i), .tx_bcast_i(tx_bcast_i),
   .cmd_clr_flags_i(cmd_clr_flags_i), .por_set(por_set),
   .idle_expire(idle_expire));

// File: tb/tnc_status_irq_bench.sv
module tnc_status_irq_bench;
   localparam int CLK_PER  = 10;
   localparam int BENCH_HZ = 1_000_000;
   localparam int IDLE     = 41;           // 41 us at 1 MHz
   localparam int WATCHDOG = 150_000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_line = 0, rx_stored = 0, rx_for_me = 0, tx_done = 0, tx_acked = 0;
   logic tx_bcast = 0, token_rx = 0, en_rx = 0, en_tx = 0, dis_tx = 0, clr = 0;
   logic sw_rst = 0, id_wr = 0, mask_wr = 0;
   logic [7:0] id_data = 8'h00, mask_data = 8'h00;
   logic [7:0] status;
   logic nak, irq;

   int n_chk = 0, n_fail = 0, cycles = 0;
   bit finished = 0, model_ok = 0;

   always #(CLK_PER/2) clk = ~clk;

   tnc_status_irq #(.CLK_HZ(BENCH_HZ)) u_tnc_status_irq (
      .clk_i(clk), .rst_ni(rst_n), .rx_line_i(rx_line), .rx_stored_i(rx_stored),
      .rx_for_me_i(rx_for_me), .tx_done_i(tx_done), .tx_acked_i(tx_acked),
      .tx_bcast_i(tx_bcast), .token_rx_i(token_rx), .cmd_en_rx_i(en_rx),
      .cmd_en_tx_i(en_tx), .cmd_dis_tx_i(dis_tx), .cmd_clr_flags_i(clr),
      .sw_reset_i(sw_rst), .nodeid_wr_i(id_wr), .nodeid_data_i(id_data),
      .mask_wr_i(mask_wr), .mask_data_i(mask_data), .status_o(status),
      .nak_req_o(nak), .irq_o(irq));

   // behavioural reference model
   bit m_ri, m_por, m_recon, m_tma, m_ta, m_arm;
   bit [7:0] m_mask;
   int m_idle;
   bit hist[$];

   always @(posedge clk) begin
      bit moved, timeout, tclr;
      if (!rst_n) begin
         m_ri = 1; m_por = 1; m_recon = 0; m_tma = 0; m_ta = 1; m_arm = 0;
         m_mask = 0; m_idle = 0; hist = '{0, 0, 0}; model_ok = 1;
      end else begin
         moved   = (hist[1] != hist[2]);
         timeout = !moved && (m_idle == IDLE - 1);
         m_idle  = (moved || timeout) ? 0 : m_idle + 1;
         hist.push_front(rx_line);
         void'(hist.pop_back());
         if (rx_stored) m_ri = 1; else if (en_rx) m_ri = 0;
         if (sw_rst || (id_wr && id_data == 8'h00)) m_por = 1; else if (clr) m_por = 0;
         if (timeout) m_recon = 1; else if (clr) m_recon = 0;
         if (tx_acked && !tx_bcast) m_tma = 1; else if (en_tx) m_tma = 0;
         tclr = token_rx && m_arm;
         if (tx_done || dis_tx) m_ta = 1; else if (tclr) m_ta = 0;
         if (en_tx) m_arm = 1; else if (tclr || dis_tx) m_arm = 0;
         if (mask_wr) m_mask = mask_data;
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic compare();
      if (!model_ok) return;
      check("R2 receiver inhibit", 32'(status[7]), 32'(m_ri));
      check("R4 power-on", 32'(status[4]), 32'(m_por));
      check("R5 reconfiguration", 32'(status[2]), 32'(m_recon));
      check("R6 acknowledged", 32'(status[1]), 32'(m_tma));
      check("R7 tx available", 32'(status[0]), 32'(m_ta));
      check("R8 fixed bits", 32'({status[6:5], status[3]}), 32'(0));
      check("R3 nak request", 32'(nak), 32'(rx_for_me && m_ri));
      check("R9 interrupt", 32'(irq),
            32'((m_ri && m_mask[7]) || (m_recon && m_mask[2]) || (m_ta && m_mask[0])));
   endtask

   task automatic quiet();
      rx_stored = 0; rx_for_me = 0; tx_done = 0; tx_acked = 0; tx_bcast = 0;
      token_rx = 0; en_rx = 0; en_tx = 0; dis_tx = 0; clr = 0; sw_rst = 0;
      id_wr = 0; mask_wr = 0;
   endtask

   task automatic cyc();
      @(posedge clk);
      #(CLK_PER/4);
      compare();
      quiet();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      quiet();
      idle(3);
      #1 rst_n = 1'b1;
      #(CLK_PER/8);
      check("R1 reset status", 32'(status), 32'h91);
      check("R1 reset irq", 32'(irq), 32'(0));

      // R3 nak while inhibited, then after enable-receive
      rx_for_me = 1; #1 check("R3 nak while inhibited", 32'(nak), 32'(1));
      cyc();
      en_rx = 1; cyc();
      check("R2 cleared by enable-receive", 32'(status[7]), 32'(0));
      rx_for_me = 1; #1 check("R3 no nak when enabled", 32'(nak), 32'(0));
      cyc();
      rx_stored = 1; cyc();
      check("R2 set by stored packet", 32'(status[7]), 32'(1));
      rx_stored = 1; en_rx = 1; cyc();
      check("R10 stored wins over enable-receive", 32'(status[7]), 32'(1));

      // R4 power-on flag
      clr = 1; cyc();
      check("R4 cleared by clear-flags", 32'(status[4]), 32'(0));
      id_wr = 1; id_data = 8'h05; cyc();
      check("R4 non-zero node id ignored", 32'(status[4]), 32'(0));
      id_wr = 1; id_data = 8'h00; cyc();
      check("R4 set by zero node id", 32'(status[4]), 32'(1));
      clr = 1; cyc();
      sw_rst = 1; cyc();
      check("R4 set by software reset", 32'(status[4]), 32'(1));
      sw_rst = 1; clr = 1; cyc();
      check("R10 software reset wins over clear", 32'(status[4]), 32'(1));

      // R6 / R7 transmit flags
      en_tx = 1; cyc();
      check("R7 TA held until token", 32'(status[0]), 32'(1));
      check("R6 cleared by enable-transmit", 32'(status[1]), 32'(0));
      token_rx = 1; cyc();
      check("R7 cleared by token", 32'(status[0]), 32'(0));
      tx_acked = 1; tx_bcast = 1; cyc();
      check("R6 broadcast not acknowledged", 32'(status[1]), 32'(0));
      tx_done = 1; cyc();
      check("R7 set by last byte", 32'(status[0]), 32'(1));
      token_rx = 1; cyc();
      check("R7 token without enable ignored", 32'(status[0]), 32'(1));
      en_tx = 1; cyc();
      token_rx = 1; cyc();
      tx_acked = 1; cyc();
      check("R6 set by acknowledge", 32'(status[1]), 32'(1));
      en_tx = 1; cyc();
      check("R6 cleared by enable-transmit", 32'(status[1]), 32'(0));
      token_rx = 1; cyc();
      dis_tx = 1; cyc();
      check("R7 set by disable-transmitter", 32'(status[0]), 32'(1));
      en_tx = 1; cyc();
      token_rx = 1; tx_done = 1; cyc();
      check("R10 last byte wins over token", 32'(status[0]), 32'(1));
      tx_acked = 1; en_tx = 1; cyc();
      check("R10 acknowledge wins over enable-transmit", 32'(status[1]), 32'(1));

      // R5 idle timer
      clr = 1; cyc();
      for (int k = 0; k < 8; k++) begin
         rx_line = ~rx_line;
         idle(10);
      end
      check("R5 no timeout while toggling", 32'(status[2]), 32'(0));
      idle(20);
      check("R5 not yet expired", 32'(status[2]), 32'(0));
      idle(30);
      check("R5 set after idle window", 32'(status[2]), 32'(1));
      clr = 1; cyc();
      check("R5 cleared by clear-flags", 32'(status[2]), 32'(0));

      // R9 interrupt masking
      mask_wr = 1; mask_data = 8'h7A; sw_rst = 1; cyc();
      check("R9 non-source mask bits ignored", 32'(irq), 32'(0));
      mask_wr = 1; mask_data = 8'h01; cyc();
      check("R9 TA unmasked", 32'(irq), 32'(1));
      mask_wr = 1; mask_data = 8'h80; en_rx = 1; cyc();
      check("R9 RI clear no irq", 32'(irq), 32'(0));
      rx_stored = 1; cyc();
      check("R9 RI unmasked", 32'(irq), 32'(1));

      // random phase: coinciding strobes checked against the model
      for (int n = 0; n < 6000; n++) begin
         rx_stored = ($urandom % 16) == 0;  en_rx  = ($urandom % 16) == 0;
         rx_for_me = ($urandom % 8) == 0;   tx_done = ($urandom % 16) == 0;
         tx_acked  = ($urandom % 16) == 0;  tx_bcast = ($urandom % 2) == 0;
         token_rx  = ($urandom % 8) == 0;   en_tx  = ($urandom % 16) == 0;
         dis_tx    = ($urandom % 32) == 0;  clr    = ($urandom % 24) == 0;
         sw_rst    = ($urandom % 64) == 0;  id_wr  = ($urandom % 32) == 0;
         id_data   = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
         mask_wr   = ($urandom % 40) == 0;  mask_data = 8'($urandom);
         if (($urandom % 60) == 0) rx_line = ~rx_line;
         cyc();
      end

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule